// File: doc/BRIEF.md
# Configuration Load Sequencer

This block steers the loading of a configuration image into a volatile memory array. A load starts when the power-on reset is released, or when the active-low program input is driven low and then released. The block first fills every memory word with zero. It then samples the mode pins once, which select who paces the data (the block itself or the data source) and whether data arrives one bit or one byte-lane group per beat. From the incoming stream it recognises a width-detection pattern when the mode is parallel, then hunts for a synchronization word. After that it checks a device identifier, writes a fixed number of image words to the array, and checks a CRC-32 residue over everything that followed the synchronization word. If every check passes, a staged startup runs and ends with `done` going high. If a check fails, a sticky error is raised.

States and their transitions are as follows. ST_HOLD moves to ST_WIPE when program is high. ST_WIPE moves to ST_MODE after the last address has been cleared. ST_MODE moves to ST_DETECT in parallel mode and to ST_HUNT in serial mode. ST_DETECT moves to ST_HUNT after a marker byte followed by a width code. ST_HUNT moves to ST_IDCHK once the sync word is seen. ST_IDCHK moves to ST_LOAD when the identifier matches and to ST_FAULT when it does not. ST_LOAD moves to ST_CRCCHK after the last image word. ST_CRCCHK moves to ST_RELEASE on a zero residue and to ST_FAULT otherwise. ST_RELEASE moves to ST_LOCKWAIT when lock waiting is enabled and to ST_DRIVE otherwise. ST_LOCKWAIT moves to ST_DRIVE when the clock reports lock. ST_DRIVE moves to ST_DONE. ST_DONE and ST_FAULT are terminal. A low program input forces ST_HOLD from any state.

Top module: `cfg_load_seq`

## Requirements
- R1: While `por_n` is low, and in the cycle after `prog_n` is sampled low in any state, `gsr_release`, `io_enable`, `done`, `cfg_error` and `mem_we` are all 0, and any load in progress is abandoned, with no further memory writes.
- R2: After `prog_n` returns high, the block writes 0 to every address from 0 up to DEPTH-1 in ascending order, one address per cycle, before any other write.
- R3: The mode pins are sampled only in the one cycle after clearing. Changing `mode_master` or `mode_parallel` later has no effect on the load in progress.
- R4: In master mode (`mode_master`=1), `cclk_en` pulses for one cycle every CLK_DIV cycles during the load, and data is taken only on those cycles. In slave mode, data is taken on cycles where `din_strobe` is 1, and `cclk_en` stays 0.
- R5: In parallel mode, byte 0xBB on `din[7:0]` followed directly by 0x11 selects 8-bit words on `din[7:0]`, and followed by 0x22 selects 16-bit words on `din[15:0]`. Any other byte restarts detection. In serial mode, `din[0]` carries one bit per beat. In every width, data arrives most significant part first.
- R6: The sync word 0xAA995566 is matched at beat granularity. Nothing before it is written to memory.
- R7: The first word after sync is compared to DEV_ID. A mismatch raises `cfg_error`, and no image word is written.
- R8: The next DEPTH words are written to addresses 0 to DEPTH-1 in ascending order, with one `mem_we` cycle per word.
- R9: CRC-32 (polynomial 0x04C11DB7, seed all ones, MSB first, no reflection, no final inversion) runs over the identifier, the image words and the CRC word. The residue must be zero, otherwise `cfg_error` is raised.
- R10: The startup order is `gsr_release`, then `io_enable`, then `done`. Without lock waiting, each one rises one cycle after the one before it.
- R11: With `wait_lock_en`=1, `io_enable` stays low after `gsr_release` until `clk_locked` is seen high, and rises one cycle after that.
- R12: `cfg_error` is sticky and keeps `done` low until `prog_n` is pulsed low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| prog_n | input | 1 | Program request, active low, restarts the load |
| mode_master | input | 1 | 1: block paces data with cclk_en; 0: source paces data with din_strobe |
| mode_parallel | input | 1 | 1: byte-lane data with width detection; 0: bit-serial data on din[0] |
| wait_lock_en | input | 1 | 1: startup waits for clk_locked |
| clk_locked | input | 1 | Clock lock indication |
| din | input | 16 | Configuration data |
| din_strobe | input | 1 | Data valid in slave mode |
| cclk_en | output | 1 | Data take enable generated in master mode |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 32 | Memory write data |
| gsr_release | output | 1 | Internal flip-flop reset released |
| io_enable | output | 1 | Output drivers enabled |
| done | output | 1 | Load complete |
| cfg_error | output | 1 | Sticky identifier or CRC failure |

## Verification
The hardest situations to reach from the ports are a program pulse in the middle of image loading and a sync word that has to be found after a broken width pattern and stray beats. To reach them, the stimulus sends a marker byte followed by a wrong code, then repeated marker bytes, then a junk word ahead of the sync word. It also cuts one serial load short after three image words, so the scoreboard can show that the writes stop and that the next load starts again with a full clear. A further stimulus changes the mode pins while a byte-wide load is still running, so that any later resampling of the pins would stall that load.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

    localparam int          DIN_W     = 16;
    localparam int          WORD_W    = 32;
    localparam logic [31:0] SYNC_WORD = 32'hAA995566;
    localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;
    localparam logic [7:0]  WID_MARK  = 8'hBB;
    localparam logic [7:0]  WID_X8    = 8'h11;
    localparam logic [7:0]  WID_X16   = 8'h22;

    typedef enum logic [1:0] {
        BUS_X1,
        BUS_X8,
        BUS_X16
    } bus_width_e;

    typedef enum logic [3:0] {
        ST_HOLD,
        ST_WIPE,
        ST_MODE,
        ST_DETECT,
        ST_HUNT,
        ST_IDCHK,
        ST_LOAD,
        ST_CRCCHK,
        ST_RELEASE,
        ST_LOCKWAIT,
        ST_DRIVE,
        ST_DONE,
        ST_FAULT
    } cfg_state_e;

    // One 32-bit word through the CRC register, most significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [31:0] word);
        logic [31:0] c;
        c = crc;
        for (int i = 31; i >= 0; i--) begin
            if (c[31] ^ word[i]) begin
                c = (c << 1) ^ CRC_POLY;
            end else begin
                c = c << 1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/cfg_cclk_gen.sv
module cfg_cclk_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (!run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == LAST);
            cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R4
    cclk_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R4
    cclk_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);

endmodule

// File: rtl/cfg_word_asm.sv
module cfg_word_asm
    import cfg_load_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              align,
    input  logic              beat,
    input  bus_width_e        width,
    input  logic [DIN_W-1:0]  din,
    output logic [WORD_W-1:0] shreg,
    output logic              upd,
    output logic              word_vld
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  step;
    logic [CNT_W-1:0]  base;
    logic [CNT_W-1:0]  sum;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        unique case (width)
            BUS_X8: begin
                step    = CNT_W'(8);
                shifted = {shreg[WORD_W-9:0], din[7:0]};
            end
            BUS_X16: begin
                step    = CNT_W'(16);
                shifted = {shreg[WORD_W-17:0], din[15:0]};
            end
            default: begin
                step    = CNT_W'(1);
                shifted = {shreg[WORD_W-2:0], din[0]};
            end
        endcase
        base = align ? '0 : cnt;
        sum  = base + step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cnt      <= '0;
            upd      <= 1'b0;
            word_vld <= 1'b0;
        end else if (flush) begin
            shreg    <= '0;
            cnt      <= '0;
            upd      <= 1'b0;
            word_vld <= 1'b0;
        end else begin
            upd      <= beat;
            word_vld <= beat && (sum == FULL);
            if (beat) begin
                shreg <= shifted;
                cnt   <= (sum == FULL) ? '0 : sum;
            end else if (align) begin
                cnt <= '0;
            end
        end
    end

    // R8
    word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

endmodule

// File: rtl/cfg_crc32.sv
module cfg_crc32
    import cfg_load_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        seed,
    input  logic        en,
    input  logic [31:0] word,
    output logic [31:0] crc_nxt
);
    logic [31:0] crc_q;

    assign crc_nxt = crc32_step(crc_q, word);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (seed) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= crc_nxt;
        end
    end

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
    import cfg_load_pkg::*;
#(
    parameter int          DEPTH   = 8,
    parameter int          CLK_DIV = 2,
    parameter logic [31:0] DEV_ID  = 32'h0A5C1E66,
    localparam int         ADDR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              prog_n,
    input  logic              mode_master,
    input  logic              mode_parallel,
    input  logic              wait_lock_en,
    input  logic              clk_locked,
    input  logic [DIN_W-1:0]  din,
    input  logic              din_strobe,
    output logic              cclk_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              gsr_release,
    output logic              io_enable,
    output logic              done,
    output logic              cfg_error
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    cfg_state_e        st_q, st_d;
    logic [ADDR_W-1:0] idx_q;
    logic              mst_q;
    logic              mark_q;
    bus_width_e        bw_q;

    logic              beat;
    logic              stream_on;
    logic              asm_beat;
    logic              sync_hit;
    logic [WORD_W-1:0] shreg;
    logic              upd;
    logic              word_vld;
    logic [31:0]       crc_nxt;
    logic              crc_en;
    logic              width_code;

    assign stream_on  = (st_q == ST_DETECT) || (st_q == ST_HUNT) || (st_q == ST_IDCHK)
                     || (st_q == ST_LOAD)   || (st_q == ST_CRCCHK);
    assign beat       = mst_q ? cclk_en : din_strobe;
    assign asm_beat   = beat && stream_on && (st_q != ST_DETECT);
    assign sync_hit   = (st_q == ST_HUNT) && upd && (shreg == SYNC_WORD);
    assign crc_en     = word_vld && ((st_q == ST_IDCHK) || (st_q == ST_LOAD) || (st_q == ST_CRCCHK));
    assign width_code = (din[7:0] == WID_X8) || (din[7:0] == WID_X16);

    cfg_cclk_gen #(.DIV(CLK_DIV)) u_cclk (
        .clk   (clk),
        .rst_n (por_n),
        .run   (mst_q && stream_on),
        .tick  (cclk_en)
    );

    cfg_word_asm u_asm (
        .clk      (clk),
        .rst_n    (por_n),
        .flush    (st_q == ST_MODE),
        .align    (sync_hit),
        .beat     (asm_beat),
        .width    (bw_q),
        .din      (din),
        .shreg    (shreg),
        .upd      (upd),
        .word_vld (word_vld)
    );

    cfg_crc32 u_crc (
        .clk     (clk),
        .rst_n   (por_n),
        .seed    (sync_hit),
        .en      (crc_en),
        .word    (shreg),
        .crc_nxt (crc_nxt)
    );

    // State register and the bookkeeping that moves with it.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q   <= ST_HOLD;
            idx_q  <= '0;
            mst_q  <= 1'b0;
            mark_q <= 1'b0;
            bw_q   <= BUS_X1;
        end else begin
            st_q <= st_d;
            unique case (st_q)
                ST_HOLD: begin
                    idx_q  <= '0;
                    mark_q <= 1'b0;
                end
                ST_WIPE: begin
                    idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
                end
                ST_MODE: begin
                    mst_q <= mode_master;
                    bw_q  <= mode_parallel ? BUS_X8 : BUS_X1;
                end
                ST_DETECT: begin
                    if (beat) begin
                        mark_q <= (din[7:0] == WID_MARK);
                        if (mark_q && (din[7:0] == WID_X16)) begin
                            bw_q <= BUS_X16;
                        end
                    end
                end
                ST_LOAD: begin
                    if (word_vld) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD:     st_d = ST_WIPE;
            ST_WIPE:     if (idx_q == LAST) st_d = ST_MODE;
            ST_MODE:     st_d = mode_parallel ? ST_DETECT : ST_HUNT;
            ST_DETECT:   if (beat && mark_q && width_code) st_d = ST_HUNT;
            ST_HUNT:     if (sync_hit) st_d = ST_IDCHK;
            ST_IDCHK:    if (word_vld) st_d = (shreg == DEV_ID) ? ST_LOAD : ST_FAULT;
            ST_LOAD:     if (word_vld && (idx_q == LAST)) st_d = ST_CRCCHK;
            ST_CRCCHK:   if (word_vld) st_d = (crc_nxt == 32'h0) ? ST_RELEASE : ST_FAULT;
            ST_RELEASE:  st_d = wait_lock_en ? ST_LOCKWAIT : ST_DRIVE;
            ST_LOCKWAIT: if (clk_locked) st_d = ST_DRIVE;
            ST_DRIVE:    st_d = ST_DONE;
            ST_DONE:     st_d = ST_DONE;
            ST_FAULT:    st_d = ST_FAULT;
            default:     st_d = ST_HOLD;
        endcase
        if (!prog_n) begin
            st_d = ST_HOLD;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        mem_we      = 1'b0;
        mem_addr    = idx_q;
        mem_wdata   = '0;
        gsr_release = 1'b0;
        io_enable   = 1'b0;
        done        = 1'b0;
        cfg_error   = 1'b0;
        unique case (st_q)
            ST_WIPE: begin
                mem_we = 1'b1;
            end
            ST_LOAD: begin
                mem_we    = word_vld;
                mem_wdata = shreg;
            end
            ST_RELEASE, ST_LOCKWAIT: begin
                gsr_release = 1'b1;
            end
            ST_DRIVE: begin
                gsr_release = 1'b1;
                io_enable   = 1'b1;
            end
            ST_DONE: begin
                gsr_release = 1'b1;
                io_enable   = 1'b1;
                done        = 1'b1;
            end
            ST_FAULT: begin
                cfg_error = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // R1
    hold_on_prog_chk: assert property (@(posedge clk) disable iff (!por_n)
        !prog_n |=> (!gsr_release && !io_enable && !done && !cfg_error && !mem_we));

    // R10
    io_after_gsr_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(io_enable) |-> $past(gsr_release));

    // R10
    done_after_io_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(done) |-> $past(io_enable));

    // R11
    lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st_q == ST_LOCKWAIT && !clk_locked && prog_n) |=> !io_enable);

    // R12
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_error && prog_n) |=> (cfg_error && !done));

endmodule

// File: tb/sim_cfg_load_seq.sv
module sim_cfg_load_seq;

    localparam int          DEPTH   = 8;
    localparam int          CLK_DIV = 2;
    localparam logic [31:0] DEV_ID  = 32'h0A5C1E66;
    localparam int          ADDR_W  = $clog2(DEPTH);
    localparam logic [31:0] SYNC    = 32'hAA995566;

    logic              clk = 1'b0;
    logic              por_n = 1'b0;
    logic              prog_n = 1'b0;
    logic              mode_master = 1'b0;
    logic              mode_parallel = 1'b0;
    logic              wait_lock_en = 1'b0;
    logic              clk_locked = 1'b0;
    logic [15:0]       din = '0;
    logic              din_strobe = 1'b0;
    logic              cclk_en;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic              gsr_release;
    logic              io_enable;
    logic              done;
    logic              cfg_error;

    int n_chk  = 0;
    int n_fail = 0;
    int cclk_hi = 0;
    bit is_master = 1'b0;
    int bw_cur = 1;

    logic [ADDR_W+31:0] exp_q[$];
    string              tag_q[$];

    always #5 clk = ~clk;

    cfg_load_seq #(.DEPTH(DEPTH), .CLK_DIV(CLK_DIV), .DEV_ID(DEV_ID)) u0 (
        .clk           (clk),
        .por_n         (por_n),
        .prog_n        (prog_n),
        .mode_master   (mode_master),
        .mode_parallel (mode_parallel),
        .wait_lock_en  (wait_lock_en),
        .clk_locked    (clk_locked),
        .din           (din),
        .din_strobe    (din_strobe),
        .cclk_en       (cclk_en),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .gsr_release   (gsr_release),
        .io_enable     (io_enable),
        .done          (done),
        .cfg_error     (cfg_error)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_ref(input logic [31:0] c_in, input logic [31:0] w);
        logic [31:0] c;
        c = c_in;
        for (int b = 31; b >= 0; b--) begin
            c = (c[31] ^ w[b]) ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
        end
        return c;
    endfunction

    // Scoreboard monitor: every write must match the head of the queue.
    always @(negedge clk) begin
        if (por_n) begin
            if (cclk_en) cclk_hi++;
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R6 actual=write %0h@%0h expected=no write", mem_wdata, mem_addr);
                end else begin
                    chk(tag_q.pop_front(), 64'({mem_addr, mem_wdata}), 64'(exp_q.pop_front()));
                end
            end
        end
    end

    task automatic send_beat(input logic [15:0] v);
        if (is_master) begin
            @(negedge clk);
            while (!cclk_en) @(negedge clk);
            din = v;
        end else begin
            @(negedge clk);
            din        = v;
            din_strobe = 1'b1;
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        if (bw_cur == 1) begin
            for (int b = 31; b >= 0; b--) send_beat({15'b0, w[b]});
        end else if (bw_cur == 8) begin
            for (int b = 3; b >= 0; b--) send_beat({8'h00, w[b*8 +: 8]});
        end else begin
            send_beat(w[31:16]);
            send_beat(w[15:0]);
        end
    endtask

    task automatic stop_stream();
        @(negedge clk);
        din_strobe = 1'b0;
        din        = '0;
    endtask

    task automatic check_startup(input bit lock);
        int t;
        t = 0;
        while (!gsr_release && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk("R10", gsr_release, 1);
        chk("R10", {io_enable, done, cfg_error}, 0);
        if (lock) begin
            repeat (5) @(negedge clk);
            chk("R11", {gsr_release, io_enable}, 2'b10);
            clk_locked = 1'b1;
            @(negedge clk);
            chk("R11", {io_enable, done}, 2'b10);
        end else begin
            @(negedge clk);
            chk("R10", {io_enable, done}, 2'b10);
        end
        @(negedge clk);
        chk("R10", {gsr_release, io_enable, done, cfg_error}, 4'b1110);
    endtask

    task automatic do_load(input bit m, input bit par, input bit x16, input bit lock,
                           input bit bad_id, input bit bad_crc, input int abort_after,
                           input bit flip, input int salt, input string tag);
        logic [31:0] dw [DEPTH];
        logic [31:0] crc;
        logic [31:0] id;
        int n;
        bw_cur = !par ? 1 : (x16 ? 16 : 8);
        is_master = m;
        id = bad_id ? (DEV_ID ^ 32'h00010000) : DEV_ID;
        exp_q.delete();
        tag_q.delete();
        for (int i = 0; i < DEPTH; i++) begin
            exp_q.push_back({ADDR_W'(i), 32'h0});
            tag_q.push_back("R2");
        end
        crc = crc_ref(32'hFFFFFFFF, id);
        for (int i = 0; i < DEPTH; i++) begin
            dw[i] = (32'h9E3779B9 * 32'(i + 1 + salt * 16)) ^ 32'(salt);
            crc = crc_ref(crc, dw[i]);
            if (!bad_id && (abort_after < 0 || i < abort_after)) begin
                exp_q.push_back({ADDR_W'(i), dw[i]});
                tag_q.push_back("R8");
            end
        end
        if (bad_crc) crc = crc ^ 32'h1;

        mode_master   = m;
        mode_parallel = par;
        wait_lock_en  = lock;
        clk_locked    = 1'b0;
        @(negedge clk);
        prog_n = 1'b0;
        @(negedge clk);
        chk("R1", {gsr_release, io_enable, done, cfg_error, mem_we}, 0);
        prog_n  = 1'b1;
        cclk_hi = 0;
        repeat (DEPTH + 4) @(negedge clk);
        if (flip) begin
            mode_parallel = ~par;
            mode_master   = ~m;
        end
        if (m) begin
            while (!cclk_en) @(negedge clk);
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (!cclk_en);
            chk("R4", n, CLK_DIV);
        end
        if (par) begin
            send_beat(16'h0000);
            send_beat(16'h00BB);
            send_beat(16'h0033);
            send_beat(16'h00BB);
            send_beat(16'h00BB);
            send_beat(x16 ? 16'h0022 : 16'h0011);
            send_word(32'h12345677);
        end else begin
            send_beat(16'h1);
            send_beat(16'h0);
            send_beat(16'h1);
        end
        send_word(SYNC);
        send_word(id);
        if (bad_id) begin
            send_word(dw[0]);
            send_word(dw[1]);
            stop_stream();
            repeat (6) @(negedge clk);
            chk("R7", cfg_error, 1);
            chk("R12", {gsr_release, done}, 0);
            repeat (20) @(negedge clk);
            chk("R12", {cfg_error, done}, 2'b10);
            chk("R7", exp_q.size(), 0);
            return;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (abort_after >= 0 && i == abort_after) begin
                stop_stream();
                repeat (4) @(negedge clk);
                prog_n = 1'b0;
                @(negedge clk);
                chk("R1", {gsr_release, io_enable, done, cfg_error, mem_we}, 0);
                chk("R1", exp_q.size(), 0);
                repeat (3) @(negedge clk);
                return;
            end
            send_word(dw[i]);
        end
        send_word(crc);
        stop_stream();
        if (bad_crc) begin
            repeat (6) @(negedge clk);
            chk("R9", cfg_error, 1);
            chk("R12", {gsr_release, io_enable, done}, 0);
            chk("R8", exp_q.size(), 0);
            return;
        end
        check_startup(lock);
        chk(tag, done, 1);
        chk("R6 R8", exp_q.size(), 0);
        if (!m) chk("R4", cclk_hi, 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {gsr_release, io_enable, done, cfg_error, mem_we, cclk_en}, 0);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1", {gsr_release, io_enable, done, cfg_error, mem_we}, 0);

        do_load(0, 0, 0, 0, 0, 0, -1, 0, 1, "R5");   // slave serial
        do_load(0, 1, 0, 0, 0, 0, -1, 1, 2, "R3");   // slave 8-bit, pins flipped mid-load
        do_load(1, 1, 1, 1, 0, 0, -1, 0, 3, "R4");   // master 16-bit, lock wait
        do_load(0, 1, 1, 0, 1, 0, -1, 0, 4, "R7");   // identifier mismatch
        do_load(0, 1, 0, 0, 0, 1, -1, 0, 5, "R9");   // CRC mismatch
        do_load(0, 0, 0, 0, 0, 0,  3, 0, 6, "R1");   // abort mid-load
        do_load(1, 0, 0, 0, 0, 0, -1, 0, 7, "R6");   // master serial after restart
        do_load(0, 1, 1, 1, 0, 0, -1, 0, 8, "R5");   // slave 16-bit, lock wait

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule